// File: doc/BRIEF.md
# Fixed Off-Time Current Chopper

This block sits between the bridge drive requests of an H-bridge controller and the gate logic of the power stage. It limits load current with fixed off-time pulse-width modulation. While one side of the bridge is driven and a digitized comparator reports that the current is above the trip level, the block forces both drive commands low for a programmed off period. Both low-side paths then carry the recirculating current. After the off period, drive resumes.

Right after every turn-on, the comparator output is masked for a blanking window, so the switching transient cannot cause a false trip. The off period is chosen by a 2-bit code in steps of 20 µs. The blanking window is 5 µs. Both are counted in clock cycles that are derived from a clock-frequency parameter.

The block also carries a 2-bit trip-level code through one register stage for the external threshold DAC. A status output is high while an off period is running.

Top module: `chop_ctrl`

## Requirements
- R1: While reset is high, and in the first cycle after it, both drive outputs, the chopping flag and the trip-level output are 0.
- R2: With the enable high and no off period running, each drive output equals its request; this holds for all four patterns 00, 01, 10 and 11.
- R3: With the enable low, both drive outputs and the chopping flag are 0. Raising the enable while one request is high counts as a turn-on.
- R4: A turn-on starts a blanking window of BLANK_US·CLK_MHZ cycles, during which the trip input is ignored. A turn-on is a request pattern with exactly one bit set, appearing after a state that was not driving or after a different pattern.
- R5: The trip input, when sampled high outside blanking, starts an off period of (code+1)·OFF_UNIT_US·CLK_MHZ cycles. The code is the off-time select value: 0 gives 20 µs, 1 gives 40 µs, 2 gives 60 µs and 3 gives 80 µs. During the off period both drive outputs are 0.
- R6: The off-time code is captured when the off period starts. Changing the code during an off period does not change its length.
- R7: When an off period ends, drive resumes at once and a new blanking window starts. With the trip input held high, the chopping flag therefore alternates between blanking-length lows and off-length highs.
- R8: If the requests drop to 00 during an off period, the off period ends in the same cycle: the chopping flag falls and the outputs follow the requests. A later one-hot request is a fresh turn-on.
- R9: If the request changes from one one-hot pattern to the other during an off period, the new drive output rises in the same cycle, the off period ends, and a fresh blanking window starts.
- R10: The chopping flag is high only while an off period is running. A trip pulse of a single cycle produces exactly one off period.
- R11: The trip-level output equals the trip-level select input delayed by one clock.
- R12: While both requests are equal (00 or 11), the trip input has no effect: no off period starts and the outputs follow the requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Drive enable |
| req_a | input | 1 | Drive request, bridge side A |
| req_b | input | 1 | Drive request, bridge side B |
| trip | input | 1 | Comparator flag: current above trip level |
| toff_sel | input | 2 | Off-time code (n+1)·20 µs |
| itrip_sel | input | 2 | Trip-level code, input |
| drv_a | output | 1 | Gated drive command, side A |
| drv_b | output | 1 | Gated drive command, side B |
| chopping | output | 1 | High while an off period runs |
| itrip_lvl | output | 2 | Registered trip-level code |

## Verification
The trip input is held high continuously for each of the four off-time codes. Measuring the lengths of the low and high runs of the chopping flag separates the blanking length from the off length and exercises the restart of blanking at the end of each off period. Single-cycle trip pulses confirm that each trip starts exactly one off period. Equal-request patterns with the trip held high confirm that only an active drive can be chopped. Request changes during an off period check that the off period is cut short in the same cycle, and that a drop to idle is handled differently from a reversal of direction. A code change during an off period checks that the length is captured at entry.

// File: rtl/chop_ctrl.sv
module chop_ctrl #(
  parameter int CLK_MHZ     = 125,
  parameter int OFF_UNIT_US = 20,
  parameter int BLANK_US    = 5
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       en,
  input  logic       req_a,
  input  logic       req_b,
  input  logic       trip,
  input  logic [1:0] toff_sel,
  input  logic [1:0] itrip_sel,
  output logic       drv_a,
  output logic       drv_b,
  output logic       chopping,
  output logic [1:0] itrip_lvl
);
  localparam int OFF_STEP  = OFF_UNIT_US * CLK_MHZ;
  localparam int OFF_MAX   = 4 * OFF_STEP;
  localparam int BLANK_CYC = BLANK_US * CLK_MHZ;
  localparam int CW        = $clog2(OFF_MAX + 1);
  localparam int BW        = $clog2(BLANK_CYC + 1);

  logic          in_off, on_q;
  logic [1:0]    pat_q;
  logic [CW-1:0] off_cnt, off_len;
  logic [BW-1:0] blk_cnt;

  wire drive_on = en & (req_a ^ req_b);
  wire restart  = drive_on & (~on_q | (pat_q != {req_a, req_b}));
  wire hold     = in_off & drive_on & ~restart;

  assign off_len   = CW'(OFF_STEP) * ({{(CW-2){1'b0}}, toff_sel} + CW'(1));
  assign chopping  = hold & ~rst;
  assign drv_a     = ~rst & en & req_a & ~hold;
  assign drv_b     = ~rst & en & req_b & ~hold;

  always_ff @(posedge clk) begin
    if (rst) begin
      in_off    <= 1'b0;
      on_q      <= 1'b0;
      pat_q     <= 2'b00;
      off_cnt   <= '0;
      blk_cnt   <= '0;
      itrip_lvl <= 2'b00;
    end else begin
      itrip_lvl <= itrip_sel;
      on_q      <= drive_on;
      pat_q     <= {req_a, req_b};
      if (!drive_on) begin
        in_off  <= 1'b0;
        off_cnt <= '0;
        blk_cnt <= '0;
      end else if (restart) begin
        in_off  <= 1'b0;
        off_cnt <= '0;
        blk_cnt <= BW'(BLANK_CYC - 1);
      end else if (in_off) begin
        if (off_cnt == CW'(1)) begin
          in_off  <= 1'b0;
          blk_cnt <= BW'(BLANK_CYC - 1);
        end
        off_cnt <= off_cnt - CW'(1);
      end else if (blk_cnt != '0) begin
        blk_cnt <= blk_cnt - BW'(1);
      end else if (trip) begin
        in_off  <= 1'b1;
        off_cnt <= off_len;
      end
    end
  end
endmodule

// File: rtl/chop_ctrl_chk.sv
module chop_ctrl_chk (
  input logic       clk,
  input logic       rst,
  input logic       en,
  input logic       req_a,
  input logic       req_b,
  input logic       trip,
  input logic [1:0] itrip_sel,
  input logic       drv_a,
  input logic       drv_b,
  input logic       chopping,
  input logic [1:0] itrip_lvl
);
  assert_idle_when_disabled_R3: assert property (@(posedge clk) disable iff (rst)
    !en |-> (!drv_a && !drv_b && !chopping));

  assert_outputs_low_in_off_R5: assert property (@(posedge clk) disable iff (rst)
    chopping |-> (!drv_a && !drv_b));

  assert_off_started_by_trip_R10: assert property (@(posedge clk) disable iff (rst)
    $rose(chopping) |-> $past(trip));

  assert_no_chop_equal_req_R12: assert property (@(posedge clk) disable iff (rst)
    (req_a == req_b) |-> !chopping);

  assert_level_delay_R11: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (itrip_lvl == $past(itrip_sel)));
endmodule

bind chop_ctrl chop_ctrl_chk u_chk (
  .clk(clk), .rst(rst), .en(en), .req_a(req_a), .req_b(req_b), .trip(trip),
  .itrip_sel(itrip_sel), .drv_a(drv_a), .drv_b(drv_b), .chopping(chopping),
  .itrip_lvl(itrip_lvl)
);

// File: tb/chop_ctrl_bench.sv
module chop_ctrl_bench;
  localparam int MHZ   = 125;
  localparam int STEP  = 20 * MHZ;
  localparam int BLANK = 5 * MHZ;

  logic clk = 0, rst = 1, en = 0, req_a = 0, req_b = 0, trip = 0;
  logic [1:0] toff_sel = 0, itrip_sel = 0;
  logic drv_a, drv_b, chopping;
  logic [1:0] itrip_lvl;
  int total = 0, bad = 0, cyc = 0;
  bit done = 0, drv_leak = 0;

  always #4 clk = ~clk;

  chop_ctrl #(.CLK_MHZ(MHZ)) u_chop_ctrl (
    .clk(clk), .rst(rst), .en(en), .req_a(req_a), .req_b(req_b), .trip(trip),
    .toff_sel(toff_sel), .itrip_sel(itrip_sel), .drv_a(drv_a), .drv_b(drv_b),
    .chopping(chopping), .itrip_lvl(itrip_lvl)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic run_len(input logic lvl, output int n);
    n = 0;
    while (chopping == lvl && n < 20000) begin
      if (lvl && (drv_a || drv_b)) drv_leak = 1;
      n++;
      @(negedge clk);
    end
  endtask

  task automatic go_idle();
    @(negedge clk);
    trip = 0; req_a = 0; req_b = 0;
    repeat (3) @(negedge clk);
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      bad++; total++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 190000);
      finish_up();
    end
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    chk({drv_a, drv_b, chopping, itrip_lvl} == 0, "R1 reset outputs", {drv_a, drv_b, chopping, itrip_lvl}, 0);
    rst = 0;
    #1 chk({drv_a, drv_b, chopping, itrip_lvl} == 0, "R1 first cycle", {drv_a, drv_b, chopping, itrip_lvl}, 0);

    for (int s = 0; s < 4; s++) begin
      @(negedge clk); itrip_sel = 2'(s);
      #1 chk(itrip_lvl == 2'(s ^ 1) || s == 0 && itrip_lvl == 0 || itrip_lvl == 2'(s - 1), "R11 not early", itrip_lvl, s - 1);
      @(negedge clk);
      chk(itrip_lvl == 2'(s), "R11 level delay", itrip_lvl, s);
    end

    en = 1;
    for (int p = 0; p < 4; p++) begin
      @(negedge clk); {req_a, req_b} = 2'(p);
      #1 chk({drv_a, drv_b} == 2'(p), "R2 pass-through", {drv_a, drv_b}, p);
      repeat (BLANK + 5) @(negedge clk);
      chk({drv_a, drv_b, chopping} == {2'(p), 1'b0}, "R2 steady, no trip", {drv_a, drv_b, chopping}, p * 2);
    end

    for (int p = 0; p < 4; p += 3) begin
      @(negedge clk); {req_a, req_b} = 2'(p); trip = 1;
      n = 0;
      for (int i = 0; i < 2 * BLANK; i++) begin
        @(negedge clk);
        if (chopping || {drv_a, drv_b} != 2'(p)) n++;
      end
      chk(n == 0, "R12 equal requests ignore trip", n, 0);
    end
    go_idle();

    for (int c = 0; c < 4; c++) begin
      toff_sel = 2'(c); req_a = 1; trip = 1;
      #1 chk(drv_a == 1, "R4 drive rises at turn-on", drv_a, 1);
      @(negedge clk);
      drv_leak = 0;
      run_len(1'b0, n); chk(n == BLANK, "R4 blanking length", n, BLANK);
      run_len(1'b1, n); chk(n == (c + 1) * STEP, "R5 off length", n, (c + 1) * STEP);
      chk(!drv_leak, "R5 outputs low during off", drv_leak, 0);
      chk(drv_a == 1, "R7 drive resumes", drv_a, 1);
      run_len(1'b0, n); chk(n == BLANK, "R7 blanking restarts", n, BLANK);
      go_idle();
    end

    toff_sel = 0; req_a = 1; trip = 1;
    @(negedge clk);
    run_len(1'b0, n);
    toff_sel = 3;
    run_len(1'b1, n); chk(n == STEP, "R6 code captured at entry", n, STEP);
    go_idle();

    toff_sel = 3; req_a = 1; trip = 1;
    @(negedge clk); run_len(1'b0, n);
    repeat (100) @(negedge clk);
    req_a = 0;
    #1 chk({drv_a, drv_b, chopping} == 0, "R8 drop ends off at once", {drv_a, drv_b, chopping}, 0);
    @(negedge clk); req_a = 1;
    #1 chk(drv_a && !chopping, "R8 follows new request", {drv_a, chopping}, 2);
    @(negedge clk); run_len(1'b0, n); chk(n == BLANK, "R8 fresh blanking", n, BLANK);

    repeat (50) @(negedge clk);
    req_a = 0; req_b = 1;
    #1 chk({drv_a, drv_b, chopping} == 3'b010, "R9 reversal ends off", {drv_a, drv_b, chopping}, 2);
    @(negedge clk); run_len(1'b0, n); chk(n == BLANK, "R9 fresh blanking", n, BLANK);

    repeat (20) @(negedge clk);
    en = 0;
    #1 chk({drv_a, drv_b, chopping} == 0, "R3 disable in off", {drv_a, drv_b, chopping}, 0);
    n = 0;
    for (int i = 0; i < 1000; i++) begin
      @(negedge clk);
      if (drv_a || drv_b || chopping) n++;
    end
    chk(n == 0, "R3 stays quiet", n, 0);
    en = 1;
    #1 chk(drv_b == 1, "R3 enable is turn-on", drv_b, 1);
    @(negedge clk); run_len(1'b0, n); chk(n == BLANK, "R3 blanking after enable", n, BLANK);
    go_idle();

    toff_sel = 1; req_b = 1;
    repeat (BLANK + 10) @(negedge clk);
    chk(!chopping, "R10 low before trip", chopping, 0);
    trip = 1; @(negedge clk); trip = 0;
    run_len(1'b1, n); chk(n == 2 * STEP, "R10 single pulse off length", n, 2 * STEP);
    n = 0;
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      if (chopping) n++;
    end
    chk(n == 0, "R10 no further off periods", n, 0);

    finish_up();
  end
endmodule